// File: doc/BRIEF.md
# Line Buffer Partition Calculator

This block sizes the line buffer that sits in front of a vertical scaler. A request carries the source viewport widths for luma and chroma, the output width, the bits stored per component, an alpha-plane enable, a 4:2:0 flag, the vertical tap counts and the rounded-up vertical scale ratios for luma and chroma. The block works out how many whole lines (partitions) of each plane fit in each of four memory arrangements. It then picks the first arrangement, in a fixed search order, that holds enough lines for the requested vertical filter.

All divisions share one restoring divider that yields one quotient bit per clock. A controller steps through the work as named states: `S_IDLE` (waiting; `start` moves to `S_LINE_Y`), `S_LINE_Y`, `S_LINE_C` and `S_LINE_A` (line sizes in memory words for luma, chroma and alpha; each leaves when the divider finishes), `S_PART_Y`, `S_PART_C` and `S_PART_A` (partition counts of the arrangement under test; `S_PART_A` goes to `S_DONE` for a forced request and to `S_JUDGE` otherwise), `S_JUDGE` (goes to `S_DONE` on a pass or after arrangement 0, else back to `S_PART_Y` with the next arrangement) and `S_DONE` (a one-cycle completion, then `S_IDLE`).

Top module: `lb_part_calc`

## Requirements
- R1: The luma line width is min(`vp_width`, `out_width`) and the chroma line width is min(`vp_width_c`, `out_width`); a width of 0 is treated as 1.
- R2: `bpc_sel` codes 0, 1, 2 and 3 mean 6, 8, 10 and 12 bits. A luma or chroma line needs ceil(width*bits/72) words. An alpha line needs ceil(luma width/6) words.
- R3: Arrangement sizes in words (luma / chroma / alpha) are: 1 = 816 / 816 / 984; 2 = 1088 / 1088 / 1312; 3 = 4448 / 1904 / 2752; 0 = 2752 / 2752 / 2752.
- R4: A plane's partition count is floor(size/line words). With `alpha_en` set, the luma count is lowered to the alpha count when that is smaller. `part_y` and `part_c` never exceed 64.
- R5: A plane passes when taps <= partitions - ratio + 2 if its ratio ceiling exceeds 2, and when taps <= partitions otherwise. An arrangement passes only if both luma and chroma pass.
- R6: Arrangements are tried in the order 1, 2, 3 (only when `fmt420` is set), then 0. `cfg_sel` reports the arrangement number and the partition counts are those of that arrangement.
- R7: With `force_max` set, there is no search. The result is arrangement 3 for 4:2:0 and arrangement 0 otherwise, with the counts of that arrangement and `cfg_err` low.
- R8: `cfg_err` is set when arrangement 0 also fails the check. In that case `cfg_sel` is 0, and `cfg_err` is otherwise low.
- R9: `start` is taken only while `busy` is low. The inputs are captured at that edge. `busy` stays high until completion. `done` is high for exactly one cycle. The results stay unchanged while idle.
- R10: After reset, `busy`, `done`, `cfg_sel`, `part_y`, `part_c` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| force_max | input | 1 | Skip the search and take the largest arrangement |
| fmt420 | input | 1 | Source is 4:2:0 |
| alpha_en | input | 1 | Alpha plane stored |
| bpc_sel | input | 2 | Stored bits per component code |
| vp_width | input | WIDTH_W | Luma viewport width |
| vp_width_c | input | WIDTH_W | Chroma viewport width |
| out_width | input | WIDTH_W | Output rectangle width |
| vtaps | input | TAP_W | Luma vertical taps |
| vtaps_c | input | TAP_W | Chroma vertical taps |
| vratio_ceil | input | RATIO_W | Ceiling of luma vertical ratio |
| vratio_ceil_c | input | RATIO_W | Ceiling of chroma vertical ratio |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_sel | output | 2 | Chosen arrangement |
| part_y | output | PART_W | Luma partitions |
| part_c | output | PART_W | Chroma partitions |
| cfg_err | output | 1 | No arrangement passes |

## Verification
The assertions assume a tap count of at least 1 and a ratio ceiling of at least 1 for each plane. They also assume that `start` is a single-cycle pulse that the driver may raise at any time. The line-word divisor is then never zero, and the pass rule compares only non-negative sums. The bench draws taps and ratios from 1 to 8 and draws widths across the full range, including 0. It raises `start` during `busy` to show that the request is ignored.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LINE_Y,
        S_LINE_C,
        S_LINE_A,
        S_PART_Y,
        S_PART_C,
        S_PART_A,
        S_JUDGE,
        S_DONE
    } lbp_state_t;

    localparam int LINE_DIV_BITS  = 72;
    localparam int LINE_ROUND     = 71;
    localparam int ALPHA_DIV      = 6;
    localparam int ALPHA_ROUND    = 5;

    function automatic int unsigned luma_words(input logic [1:0] c);
        case (c)
            2'd1:    return 816;
            2'd2:    return 1088;
            2'd3:    return 816 + 1088 + 3 * 848;
            default: return 816 + 1088 + 848;
        endcase
    endfunction

    function automatic int unsigned chroma_words(input logic [1:0] c);
        case (c)
            2'd1:    return 816;
            2'd2:    return 1088;
            2'd3:    return 816 + 1088;
            default: return 816 + 1088 + 848;
        endcase
    endfunction

    function automatic int unsigned alpha_words(input logic [1:0] c);
        case (c)
            2'd1:    return 984;
            2'd2:    return 1312;
            default: return 984 + 1312 + 456;
        endcase
    endfunction

    function automatic logic [3:0] bits_of(input logic [1:0] code);
        return 4'd6 + {1'b0, code, 1'b0};
    endfunction

    function automatic logic is_div_state(input lbp_state_t s);
        return (s == S_LINE_Y) || (s == S_LINE_C) || (s == S_LINE_A) ||
               (s == S_PART_Y) || (s == S_PART_C) || (s == S_PART_A);
    endfunction

endpackage

// File: rtl/lbp_divider.sv
module lbp_divider #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quot,
    output logic         fin
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem;
    logic [W-1:0]     den;
    logic [W-1:0]     q;
    logic [CNT_W-1:0] cnt;
    logic             run;
    logic [W:0]       shifted;
    logic [W:0]       trial;

    always_comb begin
        shifted = {rem, q[W-1]};
        trial   = shifted - {1'b0, den};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
            den <= '0;
            q   <= '0;
            cnt <= '0;
            run <= 1'b0;
            fin <= 1'b0;
        end else if (go) begin
            rem <= '0;
            den <= divisor;
            q   <= dividend;
            cnt <= CNT_W'(W);
            run <= 1'b1;
            fin <= 1'b0;
        end else if (run) begin
            if (!trial[W]) begin
                rem <= trial[W-1:0];
                q   <= {q[W-2:0], 1'b1};
            end else begin
                rem <= shifted[W-1:0];
                q   <= {q[W-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
                run <= 1'b0;
                fin <= 1'b1;
            end
        end else begin
            fin <= 1'b0;
        end
    end

    assign quot = q;

    // R4: a finished division leaves a remainder below the divisor
    a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (rem < den));

    // R9: completion is a single-cycle pulse
    a_r9_fin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);

endmodule

// File: rtl/lb_part_calc.sv
module lb_part_calc
    import lbp_pkg::*;
#(
    parameter int WIDTH_W  = 14,
    parameter int TAP_W    = 4,
    parameter int RATIO_W  = 4,
    parameter int PART_MAX = 64,
    localparam int PART_W  = $clog2(PART_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               force_max,
    input  logic               fmt420,
    input  logic               alpha_en,
    input  logic [1:0]         bpc_sel,
    input  logic [WIDTH_W-1:0] vp_width,
    input  logic [WIDTH_W-1:0] vp_width_c,
    input  logic [WIDTH_W-1:0] out_width,
    input  logic [TAP_W-1:0]   vtaps,
    input  logic [TAP_W-1:0]   vtaps_c,
    input  logic [RATIO_W-1:0] vratio_ceil,
    input  logic [RATIO_W-1:0] vratio_ceil_c,
    output logic               busy,
    output logic               done,
    output logic [1:0]         cfg_sel,
    output logic [PART_W-1:0]  part_y,
    output logic [PART_W-1:0]  part_c,
    output logic               cfg_err
);
    localparam int MEM_W = 13;
    localparam int DIV_W = (WIDTH_W + 4 > MEM_W) ? WIDTH_W + 4 : MEM_W;

    lbp_state_t state, nxt;
    logic go_r;

    logic [WIDTH_W-1:0] l_wy, l_wc;
    logic [1:0]         l_bpc;
    logic               l_alpha, l_420, l_force;
    logic [TAP_W-1:0]   l_vt, l_vtc;
    logic [RATIO_W-1:0] l_cr, l_crc;

    logic [DIV_W-1:0]  ly, lc, la;
    logic [PART_W-1:0] py_r, pc_r;
    logic [1:0]        cfg_r;
    logic              err_r;

    logic [DIV_W-1:0] num, den, quot;
    logic             div_fin;
    logic             cfg_ok;
    logic [PART_W-1:0] q_clamped;

    function automatic logic [WIDTH_W-1:0] eff_width(input logic [WIDTH_W-1:0] a,
                                                     input logic [WIDTH_W-1:0] b);
        logic [WIDTH_W-1:0] m;
        m = (a < b) ? a : b;
        return (m == '0) ? WIDTH_W'(1) : m;
    endfunction

    function automatic logic plane_ok(input logic [TAP_W-1:0] t,
                                      input logic [RATIO_W-1:0] r,
                                      input logic [PART_W-1:0] p);
        int ti, ri, pi;
        ti = int'(t);
        ri = int'(r);
        pi = int'(p);
        if (ri > 2) return (ti + ri) <= (pi + 2);
        return ti <= pi;
    endfunction

    lbp_divider #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go_r),
        .dividend (num),
        .divisor  (den),
        .quot     (quot),
        .fin      (div_fin)
    );

    always_comb begin
        num = '0;
        den = DIV_W'(1);
        unique case (state)
            S_LINE_Y: begin
                num = DIV_W'(l_wy) * DIV_W'(bits_of(l_bpc)) + DIV_W'(LINE_ROUND);
                den = DIV_W'(LINE_DIV_BITS);
            end
            S_LINE_C: begin
                num = DIV_W'(l_wc) * DIV_W'(bits_of(l_bpc)) + DIV_W'(LINE_ROUND);
                den = DIV_W'(LINE_DIV_BITS);
            end
            S_LINE_A: begin
                num = DIV_W'(l_wy) + DIV_W'(ALPHA_ROUND);
                den = DIV_W'(ALPHA_DIV);
            end
            S_PART_Y: begin num = DIV_W'(luma_words(cfg_r));   den = ly; end
            S_PART_C: begin num = DIV_W'(chroma_words(cfg_r)); den = lc; end
            S_PART_A: begin num = DIV_W'(alpha_words(cfg_r));  den = la; end
            default: ;
        endcase
    end

    assign q_clamped = (quot > DIV_W'(PART_MAX)) ? PART_W'(PART_MAX) : quot[PART_W-1:0];
    assign cfg_ok    = plane_ok(l_vt, l_cr, py_r) && plane_ok(l_vtc, l_crc, pc_r);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start)   nxt = S_LINE_Y;
            S_LINE_Y: if (div_fin) nxt = S_LINE_C;
            S_LINE_C: if (div_fin) nxt = S_LINE_A;
            S_LINE_A: if (div_fin) nxt = S_PART_Y;
            S_PART_Y: if (div_fin) nxt = S_PART_C;
            S_PART_C: if (div_fin) nxt = S_PART_A;
            S_PART_A: if (div_fin) nxt = l_force ? S_DONE : S_JUDGE;
            S_JUDGE:  nxt = (cfg_ok || cfg_r == 2'd0) ? S_DONE : S_PART_Y;
            S_DONE:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            go_r  <= 1'b0;
        end else begin
            state <= nxt;
            go_r  <= is_div_state(nxt) && (nxt != state);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_wy <= '0; l_wc <= '0; l_bpc <= '0;
            l_alpha <= 1'b0; l_420 <= 1'b0; l_force <= 1'b0;
            l_vt <= '0; l_vtc <= '0; l_cr <= '0; l_crc <= '0;
            ly <= '0; lc <= '0; la <= '0;
            py_r <= '0; pc_r <= '0; cfg_r <= '0; err_r <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    l_wy    <= eff_width(vp_width, out_width);
                    l_wc    <= eff_width(vp_width_c, out_width);
                    l_bpc   <= bpc_sel;
                    l_alpha <= alpha_en;
                    l_420   <= fmt420;
                    l_force <= force_max;
                    l_vt    <= vtaps;
                    l_vtc   <= vtaps_c;
                    l_cr    <= vratio_ceil;
                    l_crc   <= vratio_ceil_c;
                end
                S_LINE_Y: if (div_fin) ly <= quot;
                S_LINE_C: if (div_fin) lc <= quot;
                S_LINE_A: if (div_fin) begin
                    la    <= quot;
                    err_r <= 1'b0;
                    cfg_r <= l_force ? (l_420 ? 2'd3 : 2'd0) : 2'd1;
                end
                S_PART_Y: if (div_fin) py_r <= q_clamped;
                S_PART_C: if (div_fin) pc_r <= q_clamped;
                S_PART_A: if (div_fin && l_alpha && (q_clamped < py_r)) py_r <= q_clamped;
                S_JUDGE: if (!cfg_ok) begin
                    if (cfg_r == 2'd0)      err_r <= 1'b1;
                    else if (cfg_r == 2'd1) cfg_r <= 2'd2;
                    else if (cfg_r == 2'd2) cfg_r <= l_420 ? 2'd3 : 2'd0;
                    else                    cfg_r <= 2'd0;
                end
                default: ;
            endcase
        end
    end

    assign busy    = (state != S_IDLE);
    assign done    = (state == S_DONE);
    assign cfg_sel = cfg_r;
    assign part_y  = py_r;
    assign part_c  = pc_r;
    assign cfg_err = err_r;

    a_r9_accept_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(part_y) && $stable(part_c) && $stable(cfg_sel)));
    a_r4_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (part_y <= PART_W'(PART_MAX) && part_c <= PART_W'(PART_MAX)));
    a_r8_err_at_cfg0: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_err) |-> (cfg_sel == 2'd0));
    a_r5_pass_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_err && !l_force) |->
            (plane_ok(l_vt, l_cr, part_y) && plane_ok(l_vtc, l_crc, part_c)));
    a_r6_cfg3_only_420: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_sel == 2'd3) |-> l_420);
    a_r7_forced_choice: assert property (@(posedge clk) disable iff (!rst_n)
        (done && l_force) |-> (!cfg_err && cfg_sel == (l_420 ? 2'd3 : 2'd0)));

endmodule

// File: tb/tb_lb_part_calc.sv
`timescale 1ns/1ps
module tb_lb_part_calc;
    localparam int WIDTH_W = 14;
    localparam int TAP_W   = 4;
    localparam int RATIO_W = 4;
    localparam int PART_W  = 7;
    localparam int LIMIT   = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, force_max = 1'b0, fmt420 = 1'b0, alpha_en = 1'b0;
    logic [1:0] bpc_sel = '0;
    logic [WIDTH_W-1:0] vp_width = '0, vp_width_c = '0, out_width = '0;
    logic [TAP_W-1:0] vtaps = 4'd1, vtaps_c = 4'd1;
    logic [RATIO_W-1:0] vratio_ceil = 4'd1, vratio_ceil_c = 4'd1;
    logic busy, done, cfg_err;
    logic [1:0] cfg_sel;
    logic [PART_W-1:0] part_y, part_c;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lb_part_calc dut (
        .clk(clk), .rst_n(rst_n), .start(start), .force_max(force_max),
        .fmt420(fmt420), .alpha_en(alpha_en), .bpc_sel(bpc_sel),
        .vp_width(vp_width), .vp_width_c(vp_width_c), .out_width(out_width),
        .vtaps(vtaps), .vtaps_c(vtaps_c), .vratio_ceil(vratio_ceil),
        .vratio_ceil_c(vratio_ceil_c), .busy(busy), .done(done),
        .cfg_sel(cfg_sel), .part_y(part_y), .part_c(part_c), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int mem_of(input int plane, input int c);
        int t[3][4];
        t[0] = '{2752, 816, 1088, 4448};
        t[1] = '{2752, 816, 1088, 1904};
        t[2] = '{2752, 984, 1312, 2752};
        return t[plane][c];
    endfunction

    int e_cfg, e_py, e_pc, e_err;

    function automatic bit ok_plane(input int t, input int r, input int p);
        if (r > 2) return t <= p - r + 2;
        return t <= p;
    endfunction

    task automatic model();
        int wy, wc, bits, ly, lc, la, py, pc, pa;
        int order[4];
        int n;
        wy = (vp_width < out_width) ? int'(vp_width) : int'(out_width);
        wc = (vp_width_c < out_width) ? int'(vp_width_c) : int'(out_width);
        if (wy == 0) wy = 1;
        if (wc == 0) wc = 1;
        bits = 6 + 2 * int'(bpc_sel);
        ly = (wy * bits + 71) / 72;
        lc = (wc * bits + 71) / 72;
        la = (wy + 5) / 6;
        if (force_max) begin
            order[0] = fmt420 ? 3 : 0;
            n = 1;
        end else begin
            order[0] = 1; order[1] = 2;
            if (fmt420) begin order[2] = 3; order[3] = 0; n = 4; end
            else begin order[2] = 0; n = 3; end
        end
        e_err = 0;
        for (int i = 0; i < n; i++) begin
            py = mem_of(0, order[i]) / ly;
            pc = mem_of(1, order[i]) / lc;
            pa = mem_of(2, order[i]) / la;
            if (alpha_en && pa < py) py = pa;
            if (py > 64) py = 64;
            if (pc > 64) pc = 64;
            e_cfg = order[i]; e_py = py; e_pc = pc;
            if (force_max) break;
            if (ok_plane(int'(vtaps), int'(vratio_ceil), py) &&
                ok_plane(int'(vtaps_c), int'(vratio_ceil_c), pc)) break;
            if (i == n - 1) e_err = 1;
        end
    endtask

    task automatic wait_done(input string tag, output bit ok);
        int cyc;
        cyc = 0;
        while (!done && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        ok = done;
        if (!ok) begin
            n_tests++; n_fail++;
            $display("FAIL %s R9: actual no done expected done", tag);
        end
    endtask

    task automatic check_result(input string tag);
        chk({tag, " R6 cfg_sel"}, int'(cfg_sel), e_cfg);
        chk({tag, " R4 part_y"}, int'(part_y), e_py);
        chk({tag, " R4 part_c"}, int'(part_c), e_pc);
        chk({tag, " R8 cfg_err"}, int'(cfg_err), e_err);
    endtask

    task automatic run_req(input string tag);
        bit ok;
        model();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done(tag, ok);
        if (ok) begin
            check_result(tag);
            @(negedge clk);
            chk({tag, " R9 done pulse"}, int'(done), 0);
            chk({tag, " R9 idle"}, int'(busy), 0);
        end
    endtask

    task automatic set_req(input int vp, input int vpc, input int ow, input int b,
                           input bit a, input bit f420, input bit fm,
                           input int t, input int tc, input int r, input int rc);
        vp_width = WIDTH_W'(vp); vp_width_c = WIDTH_W'(vpc); out_width = WIDTH_W'(ow);
        bpc_sel = 2'(b); alpha_en = a; fmt420 = f420; force_max = fm;
        vtaps = TAP_W'(t); vtaps_c = TAP_W'(tc);
        vratio_ceil = RATIO_W'(r); vratio_ceil_c = RATIO_W'(rc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R9: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit ok;
        int scale;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy", int'(busy), 0);
        chk("R10 done", int'(done), 0);
        chk("R10 cfg_sel", int'(cfg_sel), 0);
        chk("R10 part_y", int'(part_y), 0);
        chk("R10 part_c", int'(part_c), 0);
        chk("R10 cfg_err", int'(cfg_err), 0);

        // R4 clamp to 64, arrangement 1
        set_req(100, 50, 100, 1, 0, 0, 0, 4, 4, 1, 1);
        run_req("R4 clamp");
        chk("R4 clamp direct", int'(part_y), 64);

        // R1 narrower output width wins
        set_req(4000, 4000, 1000, 3, 0, 0, 0, 2, 2, 1, 1);
        run_req("R1 min width");
        chk("R1 part_y from out_width", int'(part_y), 4);

        // R1 zero width treated as 1
        set_req(0, 0, 500, 0, 0, 0, 0, 8, 8, 1, 1);
        run_req("R1 zero width");

        // R2/R4 alpha limits luma: ly=84 ->9, la=167 ->5
        set_req(1000, 1000, 1000, 0, 1, 0, 0, 2, 2, 1, 1);
        run_req("R2 alpha limit");
        chk("R4 alpha limited part_y", int'(part_y), 5);

        // R5 ratio rule pushes to arrangement 2
        set_req(1000, 1000, 1000, 3, 0, 0, 0, 4, 1, 4, 1);
        run_req("R5 ratio rule");
        chk("R5 cfg two", int'(cfg_sel), 2);

        // R6 4:2:0 reaches arrangement 3; non-4:2:0 reaches 0
        set_req(2000, 1000, 2000, 3, 0, 1, 0, 6, 6, 1, 1);
        run_req("R6 cfg3");
        chk("R3 cfg3 luma 4448/334", int'(part_y), 13);
        set_req(2000, 1000, 2000, 3, 0, 0, 0, 6, 6, 1, 1);
        run_req("R6 cfg0");
        chk("R3 cfg0 luma 2752/334", int'(part_y), 8);

        // R8 nothing fits
        set_req(16000, 16000, 16000, 3, 0, 0, 0, 8, 8, 1, 1);
        run_req("R8 error");
        chk("R8 err set", int'(cfg_err), 1);

        // R7 forced
        set_req(100, 100, 100, 1, 0, 1, 1, 8, 8, 8, 8);
        run_req("R7 force 420");
        set_req(16000, 16000, 16000, 3, 0, 0, 1, 8, 8, 1, 1);
        run_req("R7 force 444");

        // R9 start ignored while busy; inputs changed mid-run
        set_req(1000, 1000, 1000, 3, 0, 0, 0, 4, 1, 4, 1);
        model();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R9 busy after start", int'(busy), 1);
        repeat (5) @(negedge clk);
        set_req(16000, 16000, 16000, 3, 1, 1, 1, 8, 8, 8, 8);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done("R9 ignore", ok);
        if (ok) check_result("R9 ignore");
        @(negedge clk);
        chk("R9 idle after ignored start", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk("R9 results held", int'(cfg_sel), 2);

        // random mix
        for (int k = 0; k < 150; k++) begin
            scale = int'($urandom_range(0, 2));
            set_req(int'($urandom_range(0, scale == 0 ? 600 : (scale == 1 ? 4000 : 16383))),
                    int'($urandom_range(0, scale == 0 ? 600 : 8000)),
                    int'($urandom_range(0, 16383)),
                    int'($urandom_range(0, 3)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    ($urandom_range(0, 9) == 0),
                    int'($urandom_range(1, 8)), int'($urandom_range(1, 8)),
                    int'($urandom_range(1, 8)), int'($urandom_range(1, 8)));
            run_req("R5 random");
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule